// File: doc/BRIEF.md
# Decision-Graph Function Evaluator

This block computes a single-output Boolean function of up to eight input variables, where the function is held as a decision graph in a sixteen-entry node table. Each entry names the variable it tests and describes two outgoing branches, one taken when that variable is 0 and one taken when it is 1. A branch either leads on to another entry, ends in a constant, or ends in one of the input variables. Any branch may also carry an inversion mark. The result is inverted when an odd number of marks lie on the path that was taken.

Software-visible loading is done through a simple write port while the engine is idle. A one-cycle start pulse captures the input vector and the entry to begin from. The engine then visits one entry per clock until it reaches an exit branch. It then raises done with the result, or with an error flag if the walk was malformed.

Top module: `bdd_walker`

## Requirements
- R1: While reset is asserted and after its release, busy, done, result and error are all 0.
- R2: A start pulse while busy is 0 captures var_vec and root_sel. busy is 1 and done, result and error are 0 from the next cycle on.
- R3: Node word layout is [16:14] tested variable index, [13:7] branch for a 1 value, [6:0] branch for a 0 value. A branch is {kind[6:5], payload[4:1], mark[0]}. At each entry the engine takes the 0-branch when the tested variable is 0 and the 1-branch when it is 1.
- R4: A branch of kind 01 is a constant exit, and its value is payload bit 0 before inversion.
- R5: A branch of kind 10 is a variable exit. Its value is the captured input variable indexed by payload bits [2:0], before inversion.
- R6: The result is inverted exactly when the path crossed an odd number of branches with mark = 1. Kind 00 is an internal branch whose payload is the next entry address.
- R7: The walk visits one entry per clock. For a path of N entries, done rises on the Nth rising edge after the edge that accepted start. busy and done are never both 1.
- R8: If the 16th visited entry still selects an internal branch, the walk ends with done = 1, error = 1 and result = 0.
- R9: Selecting a branch of reserved kind 11 ends the walk with done = 1, error = 1 and result = 0.
- R10: A start pulse while busy is 1 is ignored, and the running walk's result and latency are unchanged.
- R11: A table write while busy is 1 is ignored, and the entry keeps its old contents.
- R12: done, result and error hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Node table write strobe |
| tbl_waddr | input | 4 | Node table write address |
| tbl_wdata | input | 17 | Node word to write |
| start | input | 1 | Begin a walk |
| root_sel | input | 4 | Entry at which the walk begins |
| var_vec | input | 8 | Input variable values |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, outputs valid |
| result | output | 1 | Function value |
| error | output | 1 | Walk ended on an over-long path or a reserved branch kind |

## Verification
The embedded assertions check on every cycle the properties that hold regardless of the loaded graph. These are the exclusivity of busy and done, error never appearing without done, and the hold of the outputs between walks. They also check that the table and the captured vector do not change under a write or a start while busy, and that the visit count stays within the table size. Whether a loaded graph yields the correct function value can only be shown by the bench's scenarios. Those scenarios cover constant and variable exits, mark parity over several paths, exact walk latency, and the over-long and reserved-kind error endings.

// File: rtl/bdd_pkg.sv
package bdd_pkg;
  localparam int unsigned NVARS  = 8;
  localparam int unsigned VIDX_W = $clog2(NVARS);
  localparam int unsigned NODES  = 16;
  localparam int unsigned ADDR_W = $clog2(NODES);
  localparam int unsigned PAY_W  = ADDR_W;
  localparam int unsigned STEP_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    K_NODE  = 2'b00,
    K_CONST = 2'b01,
    K_VAR   = 2'b10,
    K_RSV   = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [PAY_W-1:0]  payload;
    logic              mark;
  } branch_t;

  typedef struct packed {
    logic [VIDX_W-1:0] tvar;
    branch_t           hi;
    branch_t           lo;
  } node_t;

  localparam int unsigned NODE_W = $bits(node_t);

  typedef struct packed {
    logic              cont;
    logic              leaf;
    logic              bad;
    logic [ADDR_W-1:0] next;
    logic              value;
    logic              parity;
  } step_t;
endpackage

// File: rtl/bdd_node_table.sv
module bdd_node_table
  import bdd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              lock,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NODE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output node_t             rnode
);
  logic [NODES-1:0][NODE_W-1:0] mem_q;
  logic [NODES-1:0][NODE_W-1:0] mem_d;
  logic                         wr_ok;

  assign wr_ok = we && !lock;

  always_comb begin
    mem_d = mem_q;
    if (wr_ok) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (wr_ok) mem_q <= mem_d;
  end

  assign rnode = node_t'(mem_q[raddr]);

  assert_tbl_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem_q));
endmodule

// File: rtl/bdd_branch_sel.sv
module bdd_branch_sel
  import bdd_pkg::*;
(
  input  node_t            node,
  input  logic [NVARS-1:0] vars,
  input  logic             parity_in,
  output step_t            step
);
  branch_t br;
  logic    par_n;

  always_comb begin
    br    = vars[node.tvar] ? node.hi : node.lo;
    par_n = parity_in ^ br.mark;
    step  = '0;
    step.parity = par_n;
    step.next   = br.payload[ADDR_W-1:0];
    unique case (br.kind)
      K_NODE:  step.cont = 1'b1;
      K_CONST: begin
        step.leaf  = 1'b1;
        step.value = br.payload[0] ^ par_n;
      end
      K_VAR: begin
        step.leaf  = 1'b1;
        step.value = vars[br.payload[VIDX_W-1:0]] ^ par_n;
      end
      default: step.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/bdd_walk_ctrl.sv
module bdd_walk_ctrl
  import bdd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] root_sel,
  input  logic [NVARS-1:0]  var_vec,
  input  step_t             step,
  output logic [ADDR_W-1:0] addr,
  output logic [NVARS-1:0]  vars,
  output logic              parity,
  output logic              busy,
  output logic              done,
  output logic              result,
  output logic              error
);
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              res_q, res_d;
  logic              err_q, err_d;
  logic              par_q, par_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NVARS-1:0]  vars_q, vars_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic              accept;
  logic              last_slot;

  assign accept    = start && !busy_q;
  assign last_slot = (steps_q == STEP_W'(NODES - 1));

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    res_d   = res_q;
    err_d   = err_q;
    par_d   = par_q;
    addr_d  = addr_q;
    vars_d  = vars_q;
    steps_d = steps_q;
    if (accept) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      res_d   = 1'b0;
      err_d   = 1'b0;
      par_d   = 1'b0;
      addr_d  = root_sel;
      vars_d  = var_vec;
      steps_d = '0;
    end else if (busy_q) begin
      if (step.leaf) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = step.value;
      end else if (step.bad || (step.cont && last_slot)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        err_d  = 1'b1;
      end else begin
        addr_d  = step.next;
        par_d   = step.parity;
        steps_d = steps_q + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= 1'b0;
      err_q   <= 1'b0;
      par_q   <= 1'b0;
      addr_q  <= '0;
      vars_q  <= '0;
      steps_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      res_q   <= res_d;
      err_q   <= err_d;
      par_q   <= par_d;
      addr_q  <= addr_d;
      vars_q  <= vars_d;
      steps_q <= steps_d;
    end
  end

  assign addr   = addr_q;
  assign vars   = vars_q;
  assign parity = par_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
  assign error  = err_q;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && !done_q && !err_q));
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  assert_steps_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    steps_q < STEP_W'(NODES));
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (done_q && !res_q));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(vars_q));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> ($stable(done_q) && $stable(res_q) && $stable(err_q)));
endmodule

// File: rtl/bdd_walker.sv
module bdd_walker
  import bdd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_waddr,
  input  logic [NODE_W-1:0] tbl_wdata,
  input  logic              start,
  input  logic [ADDR_W-1:0] root_sel,
  input  logic [NVARS-1:0]  var_vec,
  output logic              busy,
  output logic              done,
  output logic              result,
  output logic              error
);
  node_t             cur_node;
  step_t             step;
  logic [ADDR_W-1:0] cur_addr;
  logic [NVARS-1:0]  cur_vars;
  logic              cur_par;

  bdd_node_table u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .lock  (busy),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (cur_addr),
    .rnode (cur_node)
  );

  bdd_branch_sel u_sel (
    .node      (cur_node),
    .vars      (cur_vars),
    .parity_in (cur_par),
    .step      (step)
  );

  bdd_walk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .root_sel (root_sel),
    .var_vec  (var_vec),
    .step     (step),
    .addr     (cur_addr),
    .vars     (cur_vars),
    .parity   (cur_par),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .error    (error)
  );
endmodule

// File: tb/bdd_walker_test.sv
module bdd_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_waddr = '0;
  logic [16:0] tbl_wdata = '0;
  logic        start = 1'b0;
  logic [3:0]  root_sel = '0;
  logic [7:0]  var_vec = '0;
  logic        busy, done, result, error;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bdd_walker uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .start(start), .root_sel(root_sel),
    .var_vec(var_vec), .busy(busy), .done(done), .result(result), .error(error)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [6:0] br(input logic [1:0] k, input logic [3:0] p, input logic m);
    return {k, p, m};
  endfunction
  function automatic logic [16:0] nd(input logic [2:0] v, input logic [6:0] lo, input logic [6:0] hi);
    return {v, hi, lo};
  endfunction

  function automatic logic f_or(input logic [7:0] x);   return (x[0] & x[1]) | x[2]; endfunction
  function automatic logic f_dot(input logic [7:0] x);  return x[2] | (~x[0] & ~x[1]); endfunction
  function automatic logic f_xor(input logic [7:0] x);  return x[0] ^ x[1] ^ x[2]; endfunction

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [16:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run(input logic [7:0] v, input logic [3:0] r, output int lat);
    @(negedge clk);
    start = 1'b1; var_vec = v; root_sel = r;
    @(negedge clk);
    start = 1'b0;
    var_vec = 8'($urandom);
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  int lat;
  logic [7:0] v;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, 0);
    check("R1 error after reset", error, 0);

    // Graph A at 0..2: (x0&x1)|x2, constant exits (R3, R4)
    wr(4'd0, nd(3'd0, br(2'b00, 4'd1, 0), br(2'b00, 4'd2, 0)));
    wr(4'd1, nd(3'd2, br(2'b01, 4'd0, 0), br(2'b01, 4'd1, 0)));
    wr(4'd2, nd(3'd1, br(2'b00, 4'd1, 0), br(2'b01, 4'd1, 0)));
    for (int i = 0; i < 8; i++) begin
      v = {5'($urandom), 3'(i)};
      run(v, 4'd0, lat);
      check("R3 R4 graph A value", result, f_or(v));
      check("R2 R4 graph A no error", error, 0);
    end

    // Graph B at 4..5: x2 | (~x0&~x1), variable exits and marks (R5, R6)
    wr(4'd4, nd(3'd0, br(2'b00, 4'd5, 1), br(2'b10, 4'd2, 0)));
    wr(4'd5, nd(3'd1, br(2'b01, 4'd0, 0), br(2'b10, 4'd2, 1)));
    for (int i = 0; i < 8; i++) begin
      v = {5'($urandom), 3'(i)};
      run(v, 4'd4, lat);
      check("R5 R6 graph B value", result, f_dot(v));
    end

    // Graph C at 6..8: parity of x0..x2 through marks (R6)
    wr(4'd6, nd(3'd0, br(2'b00, 4'd7, 0), br(2'b00, 4'd7, 1)));
    wr(4'd7, nd(3'd1, br(2'b00, 4'd8, 0), br(2'b00, 4'd8, 1)));
    wr(4'd8, nd(3'd2, br(2'b10, 4'd2, 0), br(2'b10, 4'd2, 0)));
    for (int i = 0; i < 8; i++) begin
      v = {5'($urandom), 3'(i)};
      run(v, 4'd6, lat);
      check("R6 graph C value", result, f_xor(v));
      check("R7 graph C latency", lat, 3);
    end

    // Chain of 16 entries ending in constant 1 (R7)
    for (int i = 0; i < 15; i++)
      wr(4'(i), nd(3'd0, br(2'b00, 4'(i + 1), 0), br(2'b00, 4'(i + 1), 0)));
    wr(4'd15, nd(3'd0, br(2'b01, 4'd1, 0), br(2'b01, 4'd1, 0)));
    run(8'h00, 4'd0, lat);
    check("R7 16-entry latency", lat, 16);
    check("R7 16-entry value", result, 1);
    check("R8 16-entry no error", error, 0);

    // Start and table write while busy are ignored (R10, R11)
    @(negedge clk);
    start = 1'b1; var_vec = 8'h01; root_sel = 4'd0;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    repeat (2) @(negedge clk);
    start = 1'b1; root_sel = 4'd14; var_vec = 8'hFF;
    tbl_we = 1'b1; tbl_waddr = 4'd15; tbl_wdata = nd(3'd0, br(2'b01, 4'd0, 0), br(2'b01, 4'd0, 0));
    @(negedge clk);
    start = 1'b0; tbl_we = 1'b0;
    lat = 3;
    while (!done && lat < 100) begin @(negedge clk); lat = lat + 1; end
    check("R10 latency unchanged by start", lat, 16);
    check("R11 write while busy ignored", result, 1);
    repeat (5) @(negedge clk);
    check("R12 done held", done, 1);
    check("R12 result held", result, 1);

    // Loop: entry 15 back to 0 -> over-long path (R8)
    wr(4'd15, nd(3'd0, br(2'b00, 4'd0, 0), br(2'b00, 4'd0, 0)));
    run(8'h00, 4'd3, lat);
    check("R8 over-long error", error, 1);
    check("R8 over-long done", done, 1);
    check("R8 over-long result", result, 0);
    check("R8 over-long latency", lat, 16);

    // Reserved kind at root (R9)
    wr(4'd9, nd(3'd1, br(2'b11, 4'd1, 0), br(2'b01, 4'd1, 0)));
    run(8'h00, 4'd9, lat);
    check("R9 reserved error", error, 1);
    check("R9 reserved latency", lat, 1);
    run(8'h02, 4'd9, lat);
    check("R9 other branch no error", error, 0);
    check("R3 other branch value", result, 1);
    repeat (4) @(negedge clk);
    check("R12 error cleared and held", error, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule